// File: doc/BRIEF.md
# CPU status LED and display selector

This block forms the words shown on the front panel of a soft-CPU test board: an 8-bit LED bank and a 16-bit word for a four-digit display. It takes the CPU's status (run flag, halt reason, processor mode, interrupt priority, wait flag, R0 and PC), two memory activity strobes, a link busy flag, a clock-divider readout and a display register. It registers both outputs. Display scanning and switch handling sit elsewhere.

A one-bit LED select picks one of two LED contents. With the select clear, the LEDs show a status word. With it set, they show the low byte of an emulated data register. This register copies R0 only while the CPU waits. A two-bit display select picks the display source. Each memory strobe passes through a small stretcher state machine with two states. ST_IDLE means the LED is dark. A strobe moves the machine to ST_HOLD and reloads a tick counter. The machine stays in ST_HOLD while strobes keep arriving or ticks remain. After HOLD_TICKS millisecond enable pulses with no strobe, it goes back to ST_IDLE.

Top module: `panel_status_mux`

## Requirements
- R1: The display output is registered one clock after its inputs. `dsp_sel` = 0 gives `div_word`, 1 gives `pc_val`, 2 gives `disp_reg`, and 3 gives the data register value held before that edge.
- R2: With `led_sel` = 1, `led` shows bits 7:0 of the data register value held before the clock edge.
- R3: With `led_sel` = 0, status word bit 5 is `link_busy` and bit 6 is the stretched read activity. Bit 7 is the stretched write activity.
- R4: With `cpu_run` = 1, bits 4:0 are one-hot. `cpu_mode` 2'b00 is kernel: bit 4 is set if `cpu_ipl` > 0 and bit 3 if `cpu_ipl` = 0. `cpu_mode` 2'b01 is supervisor and sets bit 1. `cpu_mode` 2'b10 or 2'b11 is user and sets bit 0.
- R5: With `cpu_run` = 0, bit 4 is 1 and bits 3:0 equal `halt_code`.
- R6: The data register loads `r0_val` on every clock with `cpu_wait` = 1, and holds its value otherwise.
- R7: A strobe lights its LED bit on the next clock. The bit stays lit until HOLD_TICKS (default 2) `ce_msec` pulses have been seen with no new strobe. A new strobe restarts the count.
- R8: While `rst` is high on a clock edge, the next values of `led`, `dsp` and the data register are zero, and both stretchers return to ST_IDLE.
- R9: In kernel mode with `cpu_wait` = 1, bit 2 is set alone, whatever the value of `cpu_ipl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_msec | input | 1 | One-cycle pulse per millisecond |
| cpu_run | input | 1 | CPU running |
| halt_code | input | 4 | Halt reason code |
| cpu_mode | input | 2 | Current mode: 00 kernel, 01 supervisor, 1x user |
| cpu_ipl | input | 3 | Interrupt priority level |
| cpu_wait | input | 1 | CPU in wait state |
| r0_val | input | 16 | Value of R0 |
| pc_val | input | 16 | Program counter |
| mem_rd_act | input | 1 | Memory read activity strobe |
| mem_wr_act | input | 1 | Memory write activity strobe |
| link_busy | input | 1 | Link command busy |
| div_word | input | 16 | Clock divider readout |
| disp_reg | input | 16 | Display register |
| led_sel | input | 1 | LED content select |
| dsp_sel | input | 2 | Display source select |
| led | output | 8 | LED word |
| dsp | output | 16 | Display word |

## Verification
The checker tests on every cycle the properties that depend on only one cycle of inputs. These are the one-hot run encoding, the halt fallback, the wait-over-priority rule in kernel mode, the PC display path, the write LED lighting after a strobe, and the reset clear. Some behaviour needs history across many cycles: how long a stretched strobe stays lit after ce_msec pulses, restarting the hold with a new strobe, and the data register keeping R0 once the wait ends. Only the bench's cycle-accurate reference model can show these, and it does so in its directed and random scenarios.

// File: rtl/panel_pkg.sv
package panel_pkg;
    localparam int LED_W = 8;
    localparam int WORD_W = 16;
    localparam int HALT_W = 4;
    localparam int IPL_W = 3;

    localparam logic [1:0] MODE_KERNEL = 2'b00;
    localparam logic [1:0] MODE_SUPER  = 2'b01;

    typedef enum logic [1:0] {
        DSRC_DIV  = 2'd0,
        DSRC_PC   = 2'd1,
        DSRC_DISP = 2'd2,
        DSRC_DREG = 2'd3
    } dsp_src_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } hold_state_e;
endpackage

// File: rtl/act_stretch.sv
module act_stretch
    import panel_pkg::*;
#(
    parameter int HOLD_TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_msec,
    input  logic strobe,
    output logic lit
);
    localparam int CNT_W = $clog2(HOLD_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_TICKS);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    hold_state_e state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (strobe) begin
                    state_nx = ST_HOLD;
                    cnt_nx   = CNT_LOAD;
                end
            end
            ST_HOLD: begin
                if (strobe) begin
                    cnt_nx = CNT_LOAD;
                end else if (ce_msec) begin
                    if (cnt == CNT_ONE) begin
                        state_nx = ST_IDLE;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt - CNT_ONE;
                    end
                end
            end
            default: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    assign lit = strobe | (state == ST_HOLD);
endmodule

// File: rtl/cpu_act_enc.sv
module cpu_act_enc
    import panel_pkg::*;
(
    input  logic              cpu_run,
    input  logic [HALT_W-1:0] halt_code,
    input  logic [1:0]        cpu_mode,
    input  logic [IPL_W-1:0]  cpu_ipl,
    input  logic              cpu_wait,
    output logic [4:0]        act
);
    always_comb begin
        act = 5'b00000;
        if (!cpu_run) begin
            act = {1'b1, halt_code};
        end else if (cpu_mode == MODE_KERNEL) begin
            if (cpu_wait)
                act[2] = 1'b1;
            else if (cpu_ipl != '0)
                act[4] = 1'b1;
            else
                act[3] = 1'b1;
        end else if (cpu_mode == MODE_SUPER) begin
            act[1] = 1'b1;
        end else begin
            act[0] = 1'b1;
        end
    end
endmodule

// File: rtl/panel_status_mux.sv
module panel_status_mux
    import panel_pkg::*;
#(
    parameter int HOLD_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_msec,
    input  logic              cpu_run,
    input  logic [HALT_W-1:0] halt_code,
    input  logic [1:0]        cpu_mode,
    input  logic [IPL_W-1:0]  cpu_ipl,
    input  logic              cpu_wait,
    input  logic [WORD_W-1:0] r0_val,
    input  logic [WORD_W-1:0] pc_val,
    input  logic              mem_rd_act,
    input  logic              mem_wr_act,
    input  logic              link_busy,
    input  logic [WORD_W-1:0] div_word,
    input  logic [WORD_W-1:0] disp_reg,
    input  logic              led_sel,
    input  logic [1:0]        dsp_sel,
    output logic [LED_W-1:0]  led,
    output logic [WORD_W-1:0] dsp
);
    localparam int NSTR = 2;

    logic [NSTR-1:0] strobes, lits;
    logic [4:0] act;
    logic [WORD_W-1:0] dreg, dreg_nx, dsp_nx;
    logic [LED_W-1:0] led_nx;

    assign strobes = {mem_wr_act, mem_rd_act};

    for (genvar g = 0; g < NSTR; g++) begin : g_str
        act_stretch #(.HOLD_TICKS(HOLD_TICKS)) u_str (
            .clk(clk),
            .rst(rst),
            .ce_msec(ce_msec),
            .strobe(strobes[g]),
            .lit(lits[g])
        );
    end

    cpu_act_enc u_enc (
        .cpu_run(cpu_run),
        .halt_code(halt_code),
        .cpu_mode(cpu_mode),
        .cpu_ipl(cpu_ipl),
        .cpu_wait(cpu_wait),
        .act(act)
    );

    always_comb begin
        dreg_nx = cpu_wait ? r0_val : dreg;
        if (led_sel)
            led_nx = dreg[LED_W-1:0];
        else
            led_nx = {lits[1], lits[0], link_busy, act};
        unique case (dsp_src_e'(dsp_sel))
            DSRC_DIV:  dsp_nx = div_word;
            DSRC_PC:   dsp_nx = pc_val;
            DSRC_DISP: dsp_nx = disp_reg;
            DSRC_DREG: dsp_nx = dreg;
            default:   dsp_nx = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            led  <= '0;
            dsp  <= '0;
            dreg <= '0;
        end else begin
            led  <= led_nx;
            dsp  <= dsp_nx;
            dreg <= dreg_nx;
        end
    end
endmodule

// File: rtl/panel_status_chk.sv
module panel_status_chk (
    input logic        clk,
    input logic        rst,
    input logic        cpu_run,
    input logic [3:0]  halt_code,
    input logic [1:0]  cpu_mode,
    input logic        cpu_wait,
    input logic        mem_wr_act,
    input logic [15:0] pc_val,
    input logic        led_sel,
    input logic [1:0]  dsp_sel,
    input logic [7:0]  led,
    input logic [15:0] dsp
);
    p_run_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        (cpu_run && !led_sel) |=> ($countones(led[4:0]) == 1));

    p_halt_code_r5: assert property (@(posedge clk) disable iff (rst)
        (!cpu_run && !led_sel) |=> (led[4:0] == {1'b1, $past(halt_code)}));

    p_kernel_wait_r9: assert property (@(posedge clk) disable iff (rst)
        (cpu_run && !led_sel && cpu_mode == 2'b00 && cpu_wait) |=> (led[4:0] == 5'b00100));

    p_wr_lit_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_act && !led_sel) |=> led[7]);

    p_dsp_pc_r1: assert property (@(posedge clk) disable iff (rst)
        (dsp_sel == 2'b01) |=> (dsp == $past(pc_val)));

    p_reset_clear_r8: assert property (@(posedge clk)
        $past(rst) |-> (led == 8'h00 && dsp == 16'h0000));
endmodule

bind panel_status_mux panel_status_chk u_chk (
    .clk(clk),
    .rst(rst),
    .cpu_run(cpu_run),
    .halt_code(halt_code),
    .cpu_mode(cpu_mode),
    .cpu_wait(cpu_wait),
    .mem_wr_act(mem_wr_act),
    .pc_val(pc_val),
    .led_sel(led_sel),
    .dsp_sel(dsp_sel),
    .led(led),
    .dsp(dsp)
);

// File: tb/sim_panel_status_mux.sv
`timescale 1ns/1ps
module sim_panel_status_mux;
    localparam int HOLD = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_msec = 1'b0;
    logic cpu_run = 1'b0;
    logic [3:0] halt_code = 4'h0;
    logic [1:0] cpu_mode = 2'b00;
    logic [2:0] cpu_ipl = 3'd0;
    logic cpu_wait = 1'b0;
    logic [15:0] r0_val = 16'h0;
    logic [15:0] pc_val = 16'h0;
    logic mem_rd_act = 1'b0;
    logic mem_wr_act = 1'b0;
    logic link_busy = 1'b0;
    logic [15:0] div_word = 16'h0;
    logic [15:0] disp_reg = 16'h0;
    logic led_sel = 1'b0;
    logic [1:0] dsp_sel = 2'b00;
    logic [7:0] led;
    logic [15:0] dsp;

    int n_chk = 0;
    int n_fail = 0;
    string tag = "R8";

    logic [7:0] m_led = 8'h00;
    logic [15:0] m_dsp = 16'h0000;
    logic [15:0] m_dreg = 16'h0000;
    int cnt_rd = 0;
    int cnt_wr = 0;

    always #10 clk = ~clk;

    panel_status_mux #(.HOLD_TICKS(HOLD)) u0 (
        .clk(clk), .rst(rst), .ce_msec(ce_msec), .cpu_run(cpu_run),
        .halt_code(halt_code), .cpu_mode(cpu_mode), .cpu_ipl(cpu_ipl),
        .cpu_wait(cpu_wait), .r0_val(r0_val), .pc_val(pc_val),
        .mem_rd_act(mem_rd_act), .mem_wr_act(mem_wr_act),
        .link_busy(link_busy), .div_word(div_word), .disp_reg(disp_reg),
        .led_sel(led_sel), .dsp_sel(dsp_sel), .led(led), .dsp(dsp)
    );

    function automatic logic [4:0] act_ref();
        logic [4:0] a = 5'b0;
        if (!cpu_run) a = {1'b1, halt_code};
        else if (cpu_mode == 2'b00) begin
            if (cpu_wait) a[2] = 1'b1;
            else if (cpu_ipl > 0) a[4] = 1'b1;
            else a[3] = 1'b1;
        end else if (cpu_mode == 2'b01) a[1] = 1'b1;
        else a[0] = 1'b1;
        return a;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_led = 8'h00; m_dsp = 16'h0000; m_dreg = 16'h0000;
            cnt_rd = 0; cnt_wr = 0;
        end else begin
            logic wr_on, rd_on;
            wr_on = mem_wr_act || (cnt_wr > 0);
            rd_on = mem_rd_act || (cnt_rd > 0);
            m_led = led_sel ? m_dreg[7:0] : {wr_on, rd_on, link_busy, act_ref()};
            case (dsp_sel)
                2'd0: m_dsp = div_word;
                2'd1: m_dsp = pc_val;
                2'd2: m_dsp = disp_reg;
                default: m_dsp = m_dreg;
            endcase
            if (cpu_wait) m_dreg = r0_val;
            if (mem_wr_act) cnt_wr = HOLD;
            else if (ce_msec && cnt_wr > 0) cnt_wr--;
            if (mem_rd_act) cnt_rd = HOLD;
            else if (ce_msec && cnt_rd > 0) cnt_rd--;
        end
    end

    task automatic step();
        @(negedge clk);
        n_chk++;
        if (led !== m_led) begin
            n_fail++;
            $display("FAIL %s led actual %h expected %h at %0t", tag, led, m_led, $time);
        end
        n_chk++;
        if (dsp !== m_dsp) begin
            n_fail++;
            $display("FAIL %s dsp actual %h expected %h at %0t", tag, dsp, m_dsp, $time);
        end
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R8: reset state
        tag = "R8";
        steps(3);
        rst = 1'b0;
        // R1: each display source
        tag = "R1";
        div_word = 16'h1234; pc_val = 16'hbeef; disp_reg = 16'h5a5a;
        for (int s = 0; s < 4; s++) begin
            dsp_sel = 2'(s);
            steps(2);
        end
        // R5: halted codes
        tag = "R5";
        for (int c = 0; c < 16; c += 5) begin
            halt_code = 4'(c);
            steps(2);
        end
        // R4: run modes
        tag = "R4";
        cpu_run = 1'b1;
        cpu_mode = 2'b00; cpu_ipl = 3'd3; steps(2);
        cpu_ipl = 3'd0; steps(2);
        cpu_mode = 2'b01; steps(2);
        cpu_mode = 2'b10; steps(2);
        cpu_mode = 2'b11; steps(2);
        // R9: kernel wait wins over priority
        tag = "R9";
        cpu_mode = 2'b00; cpu_ipl = 3'd7; cpu_wait = 1'b1; r0_val = 16'h00c3;
        steps(2);
        // R6: data register loads then holds
        tag = "R6";
        cpu_wait = 1'b0; r0_val = 16'hffff; dsp_sel = 2'b11;
        steps(3);
        // R2: LED shows data register low byte
        tag = "R2";
        led_sel = 1'b1; steps(2);
        cpu_wait = 1'b1; r0_val = 16'h7e81; steps(1);
        cpu_wait = 1'b0; steps(2);
        led_sel = 1'b0;
        // R3: link busy and activity bits
        tag = "R3";
        link_busy = 1'b1; steps(2);
        link_busy = 1'b0; steps(1);
        // R7: stretch single strobes and restart
        tag = "R7";
        mem_wr_act = 1'b1; step(); mem_wr_act = 1'b0;
        steps(3);
        ce_msec = 1'b1; step(); ce_msec = 1'b0; steps(2);
        mem_rd_act = 1'b1; step(); mem_rd_act = 1'b0;
        ce_msec = 1'b1; step(); ce_msec = 1'b0; steps(2);
        mem_wr_act = 1'b1; step(); mem_wr_act = 1'b0;
        ce_msec = 1'b1; step(); ce_msec = 1'b0; steps(2);
        ce_msec = 1'b1; step(); ce_msec = 1'b0; steps(2);
        ce_msec = 1'b1; step(); ce_msec = 1'b0; steps(2);
        // random mix
        tag = "R4";
        for (int i = 0; i < 400; i++) begin
            cpu_run = 1'($urandom); halt_code = 4'($urandom);
            cpu_mode = 2'($urandom); cpu_ipl = 3'($urandom);
            cpu_wait = (($urandom % 4) == 0); r0_val = 16'($urandom);
            pc_val = 16'($urandom); div_word = 16'($urandom);
            disp_reg = 16'($urandom); link_busy = 1'($urandom);
            mem_rd_act = (($urandom % 8) == 0); mem_wr_act = (($urandom % 8) == 0);
            ce_msec = (($urandom % 5) == 0); led_sel = 1'($urandom);
            dsp_sel = 2'($urandom);
            step();
        end
        // R8: reset mid-run
        tag = "R8";
        rst = 1'b1; steps(2);
        rst = 1'b0; mem_rd_act = 1'b0; mem_wr_act = 1'b0; steps(3);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule